// File: doc/BRIEF.md
# Multi-Axis Smoothed Step Pulse Generator

This block turns a stream of constant-rate motion segments into step and direction pulses for three motor axes. Each segment names a block record in a small internal table, a number of ticks to execute, a tick period in clock cycles and a smoothing level from 0 to 3. A shared tick timer paces the segment. On every tick, each axis runs an integer line-tracing accumulator, and the accumulator decides whether that axis steps on that tick.

Each block record holds one direction bit per axis, a step total per axis and an event count, which is the step total of the dominant axis. A smoothing level L stretches the block over 2^L times as many ticks. Each tick comes 2^L times faster, so the dominant axis steps once every 2^L ticks. The other axes can then step on the ticks in between, which gives them a smoother pulse train.

Internally the accumulator keeps one fixed scale for the whole block. The threshold is the event count shifted left by the maximum level. Each tick adds the axis total shifted left by (maximum level − L). This gives the same ratio as shifting the event count left by L. A block may therefore change level from one segment to the next and still keep its step count exact. The upstream preparation logic picks the level from the tick period. Level 1 is used below 8 kHz, level 2 below 4 kHz and level 3 below 2 kHz, each as a cycle threshold equal to the clock frequency divided by the cutoff.

Top module: `multi_axis_stepper`

## Requirements
- R1: After reset, idle_o=1, seg_ready_o=1, and step_o and dir_o are all zero.
- R2: A running segment with period P ticks every max(P,1) clock cycles. The first tick comes P cycles after acceptance. At level 0, an axis whose step total equals the event count rises exactly every P cycles.
- R3: Across a whole block executed at any level L in 0..3 (one segment of event_count<<L ticks), each axis emits exactly its step total. An axis steps when accumulator + addend > event_count<<3; the threshold is then subtracted. The accumulator is preset to half the threshold.
- R4: At level L, an axis whose step total equals the event count rises every 2^L·P cycles.
- R5: Consecutive segments with the same block index continue the accumulators without a preset, even when the level changes between them. The block total stays exact when the segments' event shares add up to the event count.
- R6: When a segment starts with a block index different from the last one used (or the first since reset), the accumulators are preset. dir_o[i] takes direction bit i of the record before any step. dir_o stays stable while any step_o is high.
- R7: Each step pulse stays high for pulse_width_i cycles; a width of 0 acts as 1.
- R8: The rising step edge comes step_delay_i cycles later than it would with a delay of 0.
- R9: A segment with zero ticks is accepted and ignored. It produces no pulses, leaves idle_o high and leaves dir_o unchanged.
- R10: seg_ready_o and idle_o are high only when no segment runs and no pulse is pending or high. step_o is all low whenever idle_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_we_i | input | 1 | Write strobe for the block record table |
| rec_idx_i | input | IDX_W | Record slot to write |
| rec_dir_i | input | N_AXES | Direction bit per axis |
| rec_steps_i | input | N_AXES*STEP_W | Step totals, axis 0 in the low bits |
| rec_events_i | input | STEP_W | Block event count |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment taken on the edge where valid and ready are both high |
| seg_ticks_i | input | TIMER_W | Ticks to execute |
| seg_blk_i | input | IDX_W | Record slot used by the segment |
| seg_period_i | input | TIMER_W | Clock cycles per tick |
| seg_level_i | input | LEVEL_W | Smoothing level |
| pulse_width_i | input | PULSE_W | Step pulse width in cycles |
| step_delay_i | input | PULSE_W | Cycles from tick to rising step edge, 0 for none |
| step_o | output | N_AXES | Step pulses |
| dir_o | output | N_AXES | Direction lines |
| idle_o | output | 1 | Nothing running or pending |

## Verification
Six blocks with different step ratios, direction patterns and levels 0 through 3 are each run as a single segment, and each axis's pulses are counted. Zero-step axes, equal-total axes and sparse axes are included, to separate a wrong comparison, a wrong preset or a wrong shift. One block is then split over two segments at different levels; this separates carried accumulators from wrongly preset ones. Interval measurements on the dominant axis at levels 0 and 2 separate the tick pacing from the level scaling. Width, delay and zero-tick runs show that the pulse shaping works apart from the tracing.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/stp_tick_timer.sv
module stp_tick_timer #(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [TIMER_W-1:0] period_i,
  input  logic               run_i,
  output logic               tick_o
);
  logic [TIMER_W-1:0] cnt_q, reload_q, period_eff;

  assign period_eff = (period_i == '0) ? TIMER_W'(1) : period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= period_eff - TIMER_W'(1);
      reload_q <= period_eff - TIMER_W'(1);
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - TIMER_W'(1);
    end
  end

  assign tick_o = run_i && !load_i && (cnt_q == '0);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_q);
endmodule

// File: rtl/stp_axis_tracer.sv
module stp_axis_tracer #(
  parameter int unsigned ACC_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preset_i,
  input  logic [ACC_W-1:0] half_i,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] add_i,
  input  logic [ACC_W-1:0] thresh_i,
  output logic             fire_o
);
  logic [ACC_W-1:0] acc_q, acc_sum;

  assign acc_sum = acc_q + add_i;
  assign fire_o  = tick_i && (acc_sum > thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (preset_i) acc_q <= half_i;
    else if (tick_i)   acc_q <= fire_o ? (acc_sum - thresh_i) : acc_sum;
  end

  assert_preset_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |-> !tick_i);
  assert_acc_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (acc_q <= thresh_i));
endmodule

// File: rtl/stp_pulse_shaper.sv
module stp_pulse_shaper #(
  parameter int unsigned PULSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [PULSE_W-1:0] width_i,
  input  logic [PULSE_W-1:0] delay_i,
  output logic               step_o,
  output logic               busy_o
);
  logic               pend_q, step_q;
  logic [PULSE_W-1:0] dcnt_q, wcnt_q, width_eff;

  assign width_eff = (width_i == '0) ? PULSE_W'(1) : width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      step_q <= 1'b0;
      dcnt_q <= '0;
      wcnt_q <= '0;
    end else if (fire_i) begin
      if (delay_i == '0) begin
        pend_q <= 1'b0;
        step_q <= 1'b1;
        wcnt_q <= width_eff - PULSE_W'(1);
      end else begin
        pend_q <= 1'b1;
        step_q <= 1'b0;
        dcnt_q <= delay_i - PULSE_W'(1);
      end
    end else if (pend_q) begin
      if (dcnt_q == '0) begin
        pend_q <= 1'b0;
        step_q <= 1'b1;
        wcnt_q <= width_eff - PULSE_W'(1);
      end else begin
        dcnt_q <= dcnt_q - PULSE_W'(1);
      end
    end else if (step_q) begin
      if (wcnt_q == '0) step_q <= 1'b0;
      else              wcnt_q <= wcnt_q - PULSE_W'(1);
    end
  end

  assign step_o = step_q;
  assign busy_o = pend_q | step_q;

  assert_pend_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !step_q);
endmodule

// File: rtl/multi_axis_stepper.sv
module multi_axis_stepper
  import stp_pkg::*;
#(
  parameter int unsigned N_AXES    = 3,
  parameter int unsigned BLK_DEPTH = 4,
  parameter int unsigned STEP_W    = 32,
  parameter int unsigned TIMER_W   = 16,
  parameter int unsigned LEVEL_W   = 2,
  parameter int unsigned PULSE_W   = 8,
  localparam int unsigned IDX_W    = (BLK_DEPTH > 1) ? $clog2(BLK_DEPTH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rec_we_i,
  input  logic [IDX_W-1:0]         rec_idx_i,
  input  logic [N_AXES-1:0]        rec_dir_i,
  input  logic [N_AXES*STEP_W-1:0] rec_steps_i,
  input  logic [STEP_W-1:0]        rec_events_i,
  input  logic                     seg_valid_i,
  output logic                     seg_ready_o,
  input  logic [TIMER_W-1:0]       seg_ticks_i,
  input  logic [IDX_W-1:0]         seg_blk_i,
  input  logic [TIMER_W-1:0]       seg_period_i,
  input  logic [LEVEL_W-1:0]       seg_level_i,
  input  logic [PULSE_W-1:0]       pulse_width_i,
  input  logic [PULSE_W-1:0]       step_delay_i,
  output logic [N_AXES-1:0]        step_o,
  output logic [N_AXES-1:0]        dir_o,
  output logic                     idle_o
);
  localparam int unsigned MAX_LEVEL = (1 << LEVEL_W) - 1;
  localparam int unsigned ACC_W     = STEP_W + MAX_LEVEL + 2;

  logic [N_AXES-1:0]        rec_dir_q   [BLK_DEPTH];
  logic [N_AXES*STEP_W-1:0] rec_steps_q [BLK_DEPTH];
  logic [STEP_W-1:0]        rec_ev_q    [BLK_DEPTH];

  run_state_e         state_q;
  logic [TIMER_W-1:0] ticks_q;
  logic [LEVEL_W-1:0] level_q;
  logic [IDX_W-1:0]   cur_blk_q, last_blk_q, sel_blk;
  logic               have_blk_q;
  logic [N_AXES-1:0]  dir_q, fire, busy;
  logic               busy_any, accept, start, new_blk, tick, running;
  logic [ACC_W-1:0]   thresh, half;
  logic [LEVEL_W-1:0] shift_amt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BLK_DEPTH; i++) begin
        rec_dir_q[i]   <= '0;
        rec_steps_q[i] <= '0;
        rec_ev_q[i]    <= '0;
      end
    end else if (rec_we_i) begin
      rec_dir_q[rec_idx_i]   <= rec_dir_i;
      rec_steps_q[rec_idx_i] <= rec_steps_i;
      rec_ev_q[rec_idx_i]    <= rec_events_i;
    end
  end

  assign busy_any    = |busy;
  assign running     = (state_q == ST_RUN);
  assign seg_ready_o = !running && !busy_any;
  assign idle_o      = !running && !busy_any;
  assign accept      = seg_valid_i && seg_ready_o;
  assign start       = accept && (seg_ticks_i != '0);
  assign new_blk     = start && (!have_blk_q || (seg_blk_i != last_blk_q));
  assign sel_blk     = running ? cur_blk_q : seg_blk_i;
  assign thresh      = ACC_W'(rec_ev_q[sel_blk]) << MAX_LEVEL;
  assign half        = thresh >> 1;
  assign shift_amt   = LEVEL_W'(MAX_LEVEL) - level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ticks_q    <= '0;
      level_q    <= '0;
      cur_blk_q  <= '0;
      last_blk_q <= '0;
      have_blk_q <= 1'b0;
      dir_q      <= '0;
    end else if (start) begin
      state_q   <= ST_RUN;
      ticks_q   <= seg_ticks_i;
      level_q   <= seg_level_i;
      cur_blk_q <= seg_blk_i;
      if (new_blk) begin
        last_blk_q <= seg_blk_i;
        have_blk_q <= 1'b1;
        dir_q      <= rec_dir_q[seg_blk_i];
      end
    end else if (tick) begin
      ticks_q <= ticks_q - TIMER_W'(1);
      if (ticks_q == TIMER_W'(1)) state_q <= ST_IDLE;
    end
  end

  assign dir_o = dir_q;

  stp_tick_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .period_i (seg_period_i),
    .run_i    (running),
    .tick_o   (tick)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic [ACC_W-1:0] add;
    assign add = ACC_W'(rec_steps_q[sel_blk][a*STEP_W +: STEP_W]) << shift_amt;

    stp_axis_tracer #(.ACC_W(ACC_W)) u_tracer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .preset_i (new_blk),
      .half_i   (half),
      .tick_i   (tick),
      .add_i    (add),
      .thresh_i (thresh),
      .fire_o   (fire[a])
    );

    stp_pulse_shaper #(.PULSE_W(PULSE_W)) u_shaper (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire[a]),
      .width_i (pulse_width_i),
      .delay_i (step_delay_i),
      .step_o  (step_o[a]),
      .busy_o  (busy[a])
    );
  end

  assert_tick_in_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (state_q == ST_RUN));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (step_o == '0));
  assert_dir_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|step_o) |-> $stable(dir_o));
  assert_ticks_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (ticks_q != '0));
endmodule

// File: tb/tb_multi_axis_stepper.sv
module tb_multi_axis_stepper;
  localparam int NA = 3;
  localparam int V_N = 6;
  localparam int unsigned VX[V_N]  = '{12, 7,  9,  1, 17, 6};
  localparam int unsigned VY[V_N]  = '{ 5, 12, 4, 20, 17, 0};
  localparam int unsigned VZ[V_N]  = '{ 0, 3, 16, 13,  1, 5};
  localparam int unsigned VE[V_N]  = '{12, 12, 16, 20, 17, 6};
  localparam int unsigned VL[V_N]  = '{ 0, 1,  2,  3,  3, 2};
  localparam int unsigned VP[V_N]  = '{ 4, 4,  4,  4,  5, 4};
  localparam int unsigned VD[V_N]  = '{ 5, 2,  7,  0,  4, 3};

  logic        clk = 0, rst_ni = 0;
  logic        rec_we = 0;
  logic [1:0]  rec_idx = 0;
  logic [2:0]  rec_dir = 0;
  logic [95:0] rec_steps = 0;
  logic [31:0] rec_ev = 0;
  logic        seg_valid = 0;
  logic        seg_ready;
  logic [15:0] seg_ticks = 0, seg_period = 0;
  logic [1:0]  seg_blk = 0, seg_level = 0;
  logic [7:0]  width = 2, delay = 0;
  logic [2:0]  step, dir;
  logic        idle;

  multi_axis_stepper dut (
    .clk_i(clk), .rst_ni(rst_ni), .rec_we_i(rec_we), .rec_idx_i(rec_idx),
    .rec_dir_i(rec_dir), .rec_steps_i(rec_steps), .rec_events_i(rec_ev),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready), .seg_ticks_i(seg_ticks),
    .seg_blk_i(seg_blk), .seg_period_i(seg_period), .seg_level_i(seg_level),
    .pulse_width_i(width), .step_delay_i(delay), .step_o(step), .dir_o(dir),
    .idle_o(idle)
  );

  always #2 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0, acc_cyc = 0;
  int rises[NA], first_r[NA], second_r[NA];
  int hi_run = 0, first_w = 0;
  logic [2:0] prev = 0;
  logic [1:0] nb = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    for (int a = 0; a < NA; a++) begin
      if (step[a] && !prev[a]) begin
        rises[a] = rises[a] + 1;
        if (rises[a] == 1) first_r[a] = cyc;
        if (rises[a] == 2) second_r[a] = cyc;
      end
    end
    if (step[0]) hi_run = hi_run + 1;
    else if (prev[0]) begin
      if (first_w == 0) first_w = hi_run;
      hi_run = 0;
    end
    prev = step;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int a = 0; a < NA; a++) begin
      rises[a] = 0; first_r[a] = 0; second_r[a] = 0;
    end
    hi_run = 0; first_w = 0;
  endtask

  task automatic write_rec(input logic [1:0] idx, input logic [2:0] d,
                           input int unsigned sx, sy, sz, ev);
    @(negedge clk);
    rec_we = 1; rec_idx = idx; rec_dir = d;
    rec_steps = {sz, sy, sx}; rec_ev = ev;
    @(negedge clk);
    rec_we = 0;
  endtask

  task automatic push_seg(input int unsigned ticks, input logic [1:0] idx,
                          input int unsigned per, input int unsigned lvl, input bit clr);
    @(negedge clk);
    while (!seg_ready) @(negedge clk);
    seg_valid = 1; seg_ticks = 16'(ticks); seg_blk = idx;
    seg_period = 16'(per); seg_level = 2'(lvl);
    @(posedge clk);
    if (clr) clear_mon();
    @(negedge clk);
    acc_cyc = cyc;
    seg_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!idle && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic next_blk();
    nb = nb + 2'd1;
  endtask

  initial begin
    int d0, d3;
    clear_mon();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk(idle == 1, "R1 idle", idle, 1);
    chk(seg_ready == 1, "R1 ready", seg_ready, 1);
    chk(step == 0, "R1 step", step, 0);
    chk(dir == 0, "R1 dir", dir, 0);

    // full blocks, one segment each, all levels (R3, R6)
    for (int i = 0; i < V_N; i++) begin
      next_blk();
      write_rec(nb, 3'(VD[i]), VX[i], VY[i], VZ[i], VE[i]);
      push_seg(VE[i] << VL[i], nb, VP[i], VL[i], 1);
      chk(dir == 3'(VD[i]), "R6 dir load", dir, VD[i]);
      chk(idle == 0 && seg_ready == 0, "R10 busy while running", {idle, seg_ready}, 0);
      wait_idle();
      chk(rises[0] == VX[i], "R3 x count", rises[0], VX[i]);
      chk(rises[1] == VY[i], "R3 y count", rises[1], VY[i]);
      chk(rises[2] == VZ[i], "R3 z count", rises[2], VZ[i]);
    end
    chk(idle == 1 && seg_ready == 1, "R10 idle after block", {idle, seg_ready}, 3);

    // R2 tick pacing at level 0
    next_blk();
    write_rec(nb, 3'b001, 6, 0, 0, 6);
    push_seg(6, nb, 7, 0, 1);
    wait_idle();
    chk(second_r[0] - first_r[0] == 7, "R2 interval", second_r[0] - first_r[0], 7);
    chk(first_r[0] - acc_cyc == 7, "R2 first tick", first_r[0] - acc_cyc, 7);

    // R4 level scaling
    next_blk();
    write_rec(nb, 3'b010, 6, 3, 0, 6);
    push_seg(6 << 2, nb, 5, 2, 1);
    wait_idle();
    chk(second_r[0] - first_r[0] == 20, "R4 interval", second_r[0] - first_r[0], 20);
    chk(rises[1] == 3, "R4 y count", rises[1], 3);

    // R5 split block, level change between segments
    next_blk();
    write_rec(nb, 3'b110, 10, 7, 3, 10);
    push_seg(4, nb, 4, 0, 1);
    push_seg(6 << 2, nb, 4, 2, 0);
    wait_idle();
    chk(rises[0] == 10, "R5 x count", rises[0], 10);
    chk(rises[1] == 7, "R5 y count", rises[1], 7);
    chk(rises[2] == 3, "R5 z count", rises[2], 3);

    // R7 pulse width
    width = 3;
    next_blk();
    write_rec(nb, 3'b000, 4, 0, 0, 4);
    push_seg(4, nb, 8, 0, 1);
    wait_idle();
    chk(first_w == 3, "R7 width 3", first_w, 3);
    width = 0;
    next_blk();
    write_rec(nb, 3'b000, 4, 0, 0, 4);
    push_seg(4, nb, 8, 0, 1);
    wait_idle();
    chk(first_w == 1, "R7 width 0", first_w, 1);
    width = 2;

    // R8 step delay
    next_blk();
    write_rec(nb, 3'b011, 4, 0, 0, 4);
    push_seg(4, nb, 10, 0, 1);
    wait_idle();
    d0 = first_r[0] - acc_cyc;
    delay = 3;
    next_blk();
    write_rec(nb, 3'b011, 4, 0, 0, 4);
    push_seg(4, nb, 10, 0, 1);
    wait_idle();
    d3 = first_r[0] - acc_cyc;
    chk(d3 - d0 == 3, "R8 delay shift", d3 - d0, 3);
    chk(rises[0] == 4, "R8 count with delay", rises[0], 4);
    delay = 0;

    // R9 zero-tick segment ignored
    next_blk();
    write_rec(nb, 3'b100, 5, 5, 5, 5);
    push_seg(0, nb, 4, 0, 1);
    chk(idle == 1, "R9 idle kept", idle, 1);
    repeat (20) @(negedge clk);
    chk(rises[0] + rises[1] + rises[2] == 0, "R9 no pulses",
        rises[0] + rises[1] + rises[2], 0);
    chk(dir == 3'b011, "R9 dir unchanged", dir, 3'b011);

    summary();
  end
endmodule